// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions on a two-wire PHY management bus. The host side presents an operation select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value, then pulses `start`. The block produces the management clock from the system clock, shifts out a complete frame on the data line, and for reads returns the 16-bit register contents.

The data line is handled as three separate signals: a drive value, a drive enable and an input copy of the pad. The tristate pad sits outside the block. The input copy passes through a synchronizer before it is sampled.

Before a read accepts any data, the block checks that the PHY pulls the line low during the turnaround bit. If no PHY answers, the block clocks the bus for 32 idle cycles to bring it back to a known state. It then finishes with a no-PHY flag instead of data.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, `mdc`, `mdo_en`, `busy`, `done`, `no_phy` and `rdata` are all 0.
- R2: Each `mdc` half-period lasts exactly DIV system clocks. Every management cycle is a low half followed by a high half. `mdc` is low whenever the block is idle. DIV must be at least 2.
- R3: In the cycle after a start is accepted, `mdo_en` is 1 and `mdo` is 1. Both hold for the first 32 management cycles, which form the preamble.
- R4: After the preamble the block sends these bits, in order: 0, 1; then the opcode, which is 1,0 for a read (`wr`=0) and 0,1 for a write (`wr`=1); then the PHY address, most significant bit first; then the register address, most significant bit first. `mdo` changes only at the edge where `mdc` falls, so it stays constant while `mdc` is high.
- R5: A write continues with the turnaround bits 1,0, then the 16 data bits most significant bit first. It then releases `mdo_en` for one last management cycle, for 65 management cycles in total.
- R6: A read releases `mdo_en` at the start of management cycle 46, counting from 0, which is the first turnaround cycle. The synchronized line is sampled in the last system clock of each high half. The value sampled in cycle 46 must be 0.
- R7: When the turnaround check passes, cycles 47 to 62 provide `rdata` bits 15 down to 0. Two more released cycles follow, for 65 cycles in total, and `rdata` holds the captured word when `done` pulses.
- R8: When the turnaround sample is 1, the block runs 32 more released management cycles, for 79 in total. It then ends with `no_phy`=1 and `rdata`=0.
- R9: `busy` is 1 from the cycle after the accepted start until the last high half ends. In the following cycle `done` is 1 for exactly one system clock while `busy` is 0.
- R10: A `start` pulse while `busy` is 1 is ignored. The running frame is unchanged and no second frame follows.
- R11: Each accepted start clears `rdata` and `no_phy`. Both then hold their final values from `done` until the next accepted start, and a write ends with both at 0.
- R12: The line input passes through a two-stage synchronizer. With DIV of at least 2, the sample taken at the end of a high half reflects a value that the PHY changed at the start of that management cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transaction request, accepted only while idle |
| wr | input | 1 | 1 = write, 0 = read |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Value to write |
| rdata | output | 16 | Register value returned by a read |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Transaction in progress |
| no_phy | output | 1 | Turnaround check failed on the last read |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data line drive value |
| mdo_en | output | 1 | Data line drive enable |
| mdi | input | 1 | Data line input from the pad |

## Verification
Writes are tried with mixed, all-ones and all-zero addresses and data. Mixed values show whether the bit order and field order are correct. The all-ones and all-zero cases expose stuck bits and off-by-one field boundaries. Reads are tried with words that have only the end bits set, all ones and all zeros, which shows whether the capture window is aligned with the PHY's drive cycles. A read with no PHY separates the flush path and its longer length from a normal read. A write that follows it shows that the flag clears again. A start pulse issued in the middle of a frame, and a start issued right after `done`, show that new requests are accepted only while the block is idle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_CYC    = 32;
    localparam int HDR_BITS   = 4 + 2 * ADDR_W;
    localparam int TA_BITS    = 2;
    localparam int FLUSH_CYC  = 32;
    localparam int TX_BITS    = HDR_BITS + TA_BITS + DATA_W;
    localparam int TA_CYC     = PRE_CYC + HDR_BITS;
    localparam int LAST_CYC   = TA_CYC + TA_BITS + DATA_W;
    localparam int FLUSH_LAST = TA_CYC + FLUSH_CYC;
    localparam int CYC_W      = $clog2(FLUSH_LAST + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_FLUSH
    } seq_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } req_t;

    // Bits that follow the preamble: start, opcode, addresses and (write) turnaround plus data
    function automatic logic [TX_BITS-1:0] pack_tx(req_t r);
        if (r.wr)
            return {2'b01, 2'b01, r.phy, r.regad, 2'b10, r.wdata};
        else
            return {2'b01, 2'b10, r.phy, r.regad, {(TA_BITS + DATA_W){1'b0}}};
    endfunction

endpackage

// File: rtl/mdio_halfgen.sv
module mdio_halfgen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic half_end
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == TOP)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign half_end = run && (cnt == TOP);

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0) || run);

endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst)
            ff <= '1;
        else
            ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];

endmodule

// File: rtl/mdio_shift.sv
module mdio_shift
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [TX_BITS-1:0] load_val,
    input  logic               tx_step,
    input  logic               rx_step,
    input  logic               rx_bit,
    output logic               tx_msb,
    output logic [DATA_W-1:0]  rx_word
);
    logic [TX_BITS-1:0] tx_q;
    logic [DATA_W-1:0]  rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
            rx_q <= '0;
        end else begin
            if (tx_step)
                tx_q <= {tx_q[TX_BITS-2:0], 1'b0};
            if (rx_step)
                rx_q <= {rx_q[DATA_W-2:0], rx_bit};
        end
    end

    assign tx_msb  = tx_q[TX_BITS-1];
    assign rx_word = rx_q;

    p_rx_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!load && !rx_step) |=> $stable(rx_q));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              busy,
    output logic              no_phy,
    output logic              mdc,
    output logic              mdo,
    output logic              mdo_en,
    input  logic              mdi
);
    localparam logic [CYC_W-1:0] C_PRE   = CYC_W'(PRE_CYC);
    localparam logic [CYC_W-1:0] C_TA    = CYC_W'(TA_CYC);
    localparam logic [CYC_W-1:0] C_LAST  = CYC_W'(LAST_CYC);
    localparam logic [CYC_W-1:0] C_FLAST = CYC_W'(FLUSH_LAST);
    localparam logic [CYC_W-1:0] C_DEND  = CYC_W'(TA_CYC + DATA_W);

    seq_t             st;
    logic [CYC_W-1:0] cyc;
    logic             mdc_q, done_q, err_q, wr_q;
    logic             half_end, mdi_s, tx_msb;
    logic             accept, cyc_end, ta_fail, frame_last, flush_last;
    req_t             req;

    assign req = '{wr: wr, phy: phy_addr, regad: reg_addr, wdata: wdata};

    mdio_halfgen #(.DIV(DIV)) u_half (
        .clk(clk), .rst(rst), .run(st != ST_IDLE), .half_end(half_end)
    );

    mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(mdi), .q(mdi_s)
    );

    assign accept     = (st == ST_IDLE) && start;
    assign cyc_end    = half_end && mdc_q;
    assign ta_fail    = (st == ST_FRAME) && !wr_q && (cyc == C_TA) && mdi_s;
    assign frame_last = (st == ST_FRAME) && (cyc == C_LAST);
    assign flush_last = (st == ST_FLUSH) && (cyc == C_FLAST);

    mdio_shift u_shift (
        .clk(clk), .rst(rst),
        .load(accept), .load_val(pack_tx(req)),
        .tx_step(cyc_end && (st == ST_FRAME) && (cyc >= C_PRE)),
        .rx_step(cyc_end && (st == ST_FRAME) && !wr_q && (cyc > C_TA) && (cyc <= C_DEND)),
        .rx_bit(mdi_s),
        .tx_msb(tx_msb), .rx_word(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cyc    <= '0;
            mdc_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                st    <= ST_FRAME;
                cyc   <= '0;
                mdc_q <= 1'b0;
                wr_q  <= wr;
                err_q <= 1'b0;
            end else if ((st != ST_IDLE) && half_end) begin
                mdc_q <= !mdc_q;
                if (mdc_q) begin
                    if (frame_last || flush_last) begin
                        st     <= ST_IDLE;
                        cyc    <= '0;
                        done_q <= 1'b1;
                    end else begin
                        cyc <= cyc + 1'b1;
                        if (ta_fail) begin
                            st    <= ST_FLUSH;
                            err_q <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign mdc    = mdc_q;
    assign busy   = (st != ST_IDLE);
    assign done   = done_q;
    assign no_phy = err_q;
    assign mdo    = (st == ST_FRAME) && ((cyc < C_PRE) || tx_msb);
    assign mdo_en = (st == ST_FRAME) && (wr_q ? (cyc < C_LAST) : (cyc < C_TA));

    p_idle_mdc_low_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    p_mdo_hold_r4: assert property (@(posedge clk) disable iff (rst)
        mdc |-> $stable(mdo));

    p_release_low_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(mdo_en) |-> !mdc);

    p_flush_released_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FLUSH) |-> !mdo_en && no_phy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !mdc);

    p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !cyc_end) |=> $stable(cyc) && $stable(wr_q));

    p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(rdata) && $stable(no_phy));

endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int TB_DIV = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        done, busy, no_phy, mdc, mdo, mdo_en;
    logic        mdi = 1'b1;

    always #2 clk = ~clk;

    mdio_master #(.DIV(TB_DIV), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .start(start), .wr(wr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .rdata(rdata), .done(done), .busy(busy), .no_phy(no_phy),
        .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi)
    );

    typedef struct {
        bit          busy;
        bit          mdc;
        bit          oe;
        bit          mdo;
        bit          done;
        bit [15:0]   rd;
        bit          err;
        string       tag;
        string       oe_tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    bit [15:0]   last_rd = '0;
    bit          last_err = 1'b0;
    bit          phy_present = 1'b1;
    bit [15:0]   phy_data = '0;
    int          rises = 0;
    bit          prev_mdc = 1'b0;
    int          cycles = 0;

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    function automatic exp_t idle_e();
        exp_t e;
        e.busy = 0; e.mdc = 0; e.oe = 0; e.mdo = 0; e.done = 0;
        e.rd = '0; e.err = 0; e.tag = "R11"; e.oe_tag = "R11";
        return e;
    endfunction

    // Behavioural expectation: one entry per system clock
    task automatic push_frame(bit w, bit [4:0] pa, bit [4:0] ra, bit [15:0] wd,
                              bit present, bit [15:0] pdata);
        bit [31:0] tx;
        int        ncyc;
        exp_t      e;
        tx   = w ? {2'b01, 2'b01, pa, ra, 2'b10, wd} : {2'b01, 2'b10, pa, ra, 18'b0};
        ncyc = (w || present) ? 65 : 79;
        q.push_back(idle_e());
        for (int k = 0; k < ncyc; k++) begin
            e = idle_e();
            e.busy = 1;
            e.oe   = w ? (k < 64) : (k < 46);
            e.mdo  = (k < 32) ? 1'b1 : ((k < 64) ? tx[63-k] : 1'b0);
            e.tag  = (k < 32) ? "R3" : ((k < 46) ? "R4" : "R5");
            if (k < 32)       e.oe_tag = "R3";
            else if (k < 46)  e.oe_tag = "R4";
            else if (w)       e.oe_tag = "R5";
            else if (present) e.oe_tag = "R6";
            else              e.oe_tag = "R8";
            for (int h = 0; h < 2; h++)
                for (int d = 0; d < TB_DIV; d++) begin
                    e.mdc = h[0];
                    q.push_back(e);
                end
        end
        e = idle_e();
        e.done = 1;
        e.rd   = (!w && present) ? pdata : 16'h0;
        e.err  = !w && !present;
        e.tag  = w ? "R11" : (present ? "R7" : "R8");
        q.push_back(e);
    endtask

    // Monitor and comparison, away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (q.size() > 0) e = q.pop_front();
            else              e = idle_e();
            chk(busy == e.busy, "R9", "busy", busy, e.busy);
            chk(mdc == e.mdc, "R2", "mdc", mdc, e.mdc);
            chk(mdo_en == e.oe, e.oe_tag, "mdo_en", mdo_en, e.oe);
            if (e.oe) chk(mdo == e.mdo, e.tag, "mdo", mdo, e.mdo);
            chk(done == e.done, "R9", "done", done, e.done);
            if (e.done) begin
                chk(rdata == e.rd, e.tag, "rdata (R12 sync path)", rdata, e.rd);
                chk(no_phy == e.err, e.tag, "no_phy", no_phy, e.err);
                last_rd  = e.rd;
                last_err = e.err;
            end else if (!e.busy) begin
                chk(rdata == last_rd, "R11", "rdata hold", rdata, last_rd);
                chk(no_phy == last_err, "R11", "no_phy hold", no_phy, last_err);
            end
        end
    end

    // PHY model: changes the line when the clock falls, for the cycle now starting
    always @(negedge clk) begin
        if (!busy) begin
            rises = 0;
            mdi   = 1'b1;
        end else begin
            if (!prev_mdc && mdc) rises++;
            if (prev_mdc && !mdc) begin
                if (rises == 46)                     mdi = phy_present ? 1'b0 : 1'b1;
                else if (rises >= 47 && rises <= 62) mdi = phy_data[62-rises];
                else                                 mdi = 1'b1;
            end
        end
        prev_mdc = mdc;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run(bit w, bit [4:0] pa, bit [4:0] ra, bit [15:0] wd,
                       bit present, bit [15:0] pdata, int poke_at);
        @(posedge clk); #1;
        phy_present = present;
        phy_data    = pdata;
        wr = w; phy_addr = pa; reg_addr = ra; wdata = wd;
        push_frame(w, pa, ra, wd, present, pdata);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke_at > 0) begin
            repeat (poke_at) @(posedge clk);
            #1;
            wr = ~w; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (q.size() > 0) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(mdc == 0, "R1", "mdc", mdc, 0);
        chk(mdo_en == 0, "R1", "mdo_en", mdo_en, 0);
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(no_phy == 0, "R1", "no_phy", no_phy, 0);
        chk(rdata == 0, "R1", "rdata", rdata, 0);
        rst = 1'b0;
        repeat (3) @(posedge clk);

        run(1, 5'h01, 5'h1F, 16'hA5C3, 1, 16'h0, 0);          // R5 mixed write
        run(0, 5'h10, 5'h00, 16'h0, 1, 16'h8001, 0);          // R7 end bits
        run(0, 5'h0A, 5'h15, 16'h0, 0, 16'h1234, 0);          // R8 no PHY
        run(1, 5'h1F, 5'h1F, 16'hFFFF, 1, 16'h0, 0);          // R11 clears flag
        run(1, 5'h00, 5'h00, 16'h0000, 1, 16'h0, 0);
        run(0, 5'h13, 5'h0C, 16'h0, 1, 16'hFFFF, 0);
        run(0, 5'h07, 5'h18, 16'h0, 1, 16'h0000, 0);
        run(1, 5'h0C, 5'h03, 16'h3C5A, 1, 16'h0, 40);         // R10 poke mid frame
        repeat (20) @(posedge clk);
        #1;
        chk(busy == 0, "R10", "busy after ignored start", busy, 0);
        chk(rdata == 0, "R10", "rdata after ignored start", rdata, 0);
        run(0, 5'h15, 5'h0A, 16'h0, 1, 16'h6B2D, 200);        // R10 poke during read
        run(0, 5'h01, 5'h02, 16'h0, 1, 16'hC0DE, 0);          // right after done
        repeat (10) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule